// File: doc/BRIEF.md
# Way-Partitioned LRU Victim Selector

This block chooses which way of a four-way set-associative cache to refill on a miss. It keeps a complete recency ordering of the four ways for every set, and it serves both instruction fetches and data references through a single access port. A two-bit partition mode can confine each access type to its own group of ways. Instruction and data traffic then share the cache without evicting each other's lines, while lookups may still hit in any way.

Each cycle carries at most one access. An access is a hit report (the hit way is touched) or an allocate request (a victim is chosen from the permitted group and then touched, because it is about to be filled). The victim appears on the output one clock after the request. The partition mode is taken from its input only in idle cycles. A mode change therefore never lands in the middle of cache traffic.

Top module: `wplru_victim_sel`

## Requirements
- R1: After reset `victim_vld_o` is 0, and every set is ordered with way 0 least recent, then way 1, then way 2, with way 3 most recent.
- R2: An allocate request (`alloc_i`=1, `hit_i`=0) in cycle t gives `victim_vld_o`=1 in cycle t+1, with the victim on `victim_o`. In every other case `victim_vld_o` is 0 in the following cycle.
- R3: In partition mode 0 (`mode_i`=2'b00), and in mode 3 (2'b11, handled as mode 0), the victim is the least recent of all four ways, for both access types.
- R4: In mode 1 (2'b01), an instruction access (`acc_is_data_i`=0) gets the least recent of ways 0 and 1. A data access (`acc_is_data_i`=1) gets the least recent of ways 2 and 3.
- R5: In mode 2 (2'b10), an instruction access gets the least recent of ways 0, 1 and 2. A data access always gets way 3.
- R6: A hit makes `hit_way_i` the most recent way of its set, whichever group that way belongs to.
- R7: A returned victim becomes the most recent way of its set.
- R8: When `hit_i` and `alloc_i` are both 1 in the same cycle, the hit is applied and the allocate is ignored: no victim is returned and no extra way is touched.
- R9: The partition mode is taken from `mode_i` only in a cycle with `hit_i`=0 and `alloc_i`=0, and it applies from the next cycle. In cycles with a hit or an allocate, `mode_i` is ignored.
- R10: Hits and allocations change only the ordering of the set on `acc_set_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Requested partition mode, taken when idle |
| acc_set_i | input | SET_W | Set index of the access |
| acc_is_data_i | input | 1 | 1 for a data reference, 0 for an instruction fetch |
| hit_i | input | 1 | Access hit in the cache |
| hit_way_i | input | 2 | Way that hit |
| alloc_i | input | 1 | Miss: request a victim for refill |
| victim_o | output | 2 | Selected victim way |
| victim_vld_o | output | 1 | `victim_o` is valid this cycle |

## Verification
A corrupted pairwise recency bit does not show up until the affected set is next asked for a victim. At that point it returns the wrong way, or a way outside the permitted group. For that reason the bench replays long touch and allocate sequences against a timestamp model and compares every victim. A wrongly latched partition mode shows up on the very next allocate as a victim outside its group. The group checks in the checker module catch that one cycle after the request.

// File: rtl/wplru_pkg.sv
// Package: shared types and recency helpers for the partitioned LRU selector.
// Assumes exactly four ways. Recency is stored as one bit per unordered pair
// of ways: bit(i,j), i<j, is 1 when way i is more recent than way j.
package wplru_pkg;
    localparam int WAYS  = 4;
    localparam int WAY_W = 2;
    localparam int PAIRS = WAYS * (WAYS - 1) / 2;

    typedef logic [PAIRS-1:0] lru_order_t;
    typedef logic [WAYS-1:0]  way_mask_t;

    typedef enum logic [1:0] {
        PART_SHARED = 2'b00,
        PART_HALF   = 2'b01,
        PART_3I_1D  = 2'b10,
        PART_RSVD   = 2'b11
    } part_mode_e;

    // Bit position of pair (i,j), i<j.
    function automatic int pair_pos(input int i, input int j);
        return i * (2 * WAYS - i - 1) / 2 + (j - i - 1);
    endfunction

    // True when way a was used more recently than way b.
    function automatic logic is_newer(input lru_order_t s, input int a, input int b);
        if (a < b) return s[pair_pos(a, b)];
        return !s[pair_pos(b, a)];
    endfunction

    // Make way w the most recent way in ordering s.
    function automatic lru_order_t touch_way(input lru_order_t s, input int w);
        lru_order_t r;
        r = s;
        for (int i = 0; i < WAYS; i++) begin
            for (int j = i + 1; j < WAYS; j++) begin
                if (i == w) r[pair_pos(i, j)] = 1'b1;
                if (j == w) r[pair_pos(i, j)] = 1'b0;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/wplru_group_mask.sv
// Module: maps the partition mode and access type to the set of ways that the
// access may allocate into. Assumes four ways. The reserved mode is treated
// as fully shared.
module wplru_group_mask
    import wplru_pkg::*;
(
    input  part_mode_e mode,
    input  logic       is_data,
    output way_mask_t  mask
);
    // Decode the permitted way group.
    always_comb begin
        unique case (mode)
            PART_HALF:  mask = is_data ? 4'b1100 : 4'b0011;
            PART_3I_1D: mask = is_data ? 4'b1000 : 4'b0111;
            default:    mask = 4'b1111;
        endcase
    end
endmodule

// File: rtl/wplru_pick.sv
// Module: picks the least recent way among the ways enabled in a mask.
// Assumes the mask is never empty and the ordering is a full order, so
// exactly one candidate exists.
module wplru_pick
    import wplru_pkg::*;
(
    input  lru_order_t       order,
    input  way_mask_t        mask,
    output logic [WAY_W-1:0] victim
);
    way_mask_t cand;

    for (genvar v = 0; v < WAYS; v++) begin : g_cand
        logic ok;
        // Way v qualifies when every other enabled way is newer than it.
        always_comb begin
            ok = mask[v];
            for (int u = 0; u < WAYS; u++) begin
                if (u != v && mask[u] && !is_newer(order, u, v)) ok = 1'b0;
            end
        end
        assign cand[v] = ok;
    end

    // Encode the single candidate.
    always_comb begin
        victim = '0;
        for (int v = 0; v < WAYS; v++) begin
            if (cand[v]) victim = WAY_W'(v);
        end
    end
endmodule

// File: rtl/wplru_store.sv
// Module: per-set recency storage with one read port and one touch port.
// Assumes one update per cycle. An update rewrites the addressed set so that
// the touched way becomes most recent. Reset gives the order 0<1<2<3.
module wplru_store
    import wplru_pkg::*;
#(
    parameter int NSETS = 8,
    localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             upd_en,
    input  logic [WAY_W-1:0] upd_way,
    output lru_order_t       order
);
    lru_order_t mem [NSETS];

    assign order = mem[set_idx];

    // Reset all sets or touch the addressed set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) mem[s] <= '0;
        end else if (upd_en) begin
            mem[set_idx] <= touch_way(mem[set_idx], int'(upd_way));
        end
    end
endmodule

// File: rtl/wplru_victim_sel.sv
// Module: top of the way-partitioned LRU victim selector. A hit touches the
// hit way. An allocate chooses the least recent permitted way, registers it
// as the victim and touches it. The hit wins when both are asserted. The
// partition mode is latched only in idle cycles.
module wplru_victim_sel
    import wplru_pkg::*;
#(
    parameter int NSETS = 8,
    localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [SET_W-1:0] acc_set_i,
    input  logic             acc_is_data_i,
    input  logic             hit_i,
    input  logic [WAY_W-1:0] hit_way_i,
    input  logic             alloc_i,
    output logic [WAY_W-1:0] victim_o,
    output logic             victim_vld_o
);
    part_mode_e       mode_q;
    lru_order_t       cur_order;
    way_mask_t        grp_mask;
    logic [WAY_W-1:0] pick_way;
    logic             do_alloc;
    logic             idle;
    logic             upd_en;
    logic [WAY_W-1:0] upd_way;

    assign do_alloc = alloc_i && !hit_i;
    assign idle     = !hit_i && !alloc_i;
    assign upd_en   = hit_i || do_alloc;
    assign upd_way  = hit_i ? hit_way_i : pick_way;

    wplru_store #(.NSETS(NSETS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_idx (acc_set_i),
        .upd_en  (upd_en),
        .upd_way (upd_way),
        .order   (cur_order)
    );

    wplru_group_mask u_mask (
        .mode    (mode_q),
        .is_data (acc_is_data_i),
        .mask    (grp_mask)
    );

    wplru_pick u_pick (
        .order  (cur_order),
        .mask   (grp_mask),
        .victim (pick_way)
    );

    // Latch the partition mode only when no access is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_q <= PART_SHARED;
        else if (idle) mode_q <= part_mode_e'(mode_i);
    end

    // Register the victim one cycle after the allocate request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_o     <= '0;
            victim_vld_o <= 1'b0;
        end else begin
            victim_vld_o <= do_alloc;
            if (do_alloc) victim_o <= pick_way;
        end
    end
endmodule

// File: rtl/wplru_victim_sel_chk.sv
// Checker: temporal properties of the victim selector, bound to the top.
module wplru_victim_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_q,
    input logic       acc_is_data_i,
    input logic       hit_i,
    input logic       alloc_i,
    input logic [1:0] victim_o,
    input logic       victim_vld_o
);
    // R2: an allocate without a hit yields a victim in the next cycle
    a_r2_victim_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !hit_i) |=> victim_vld_o);

    // R8: no victim after an idle cycle or a hit
    a_r8_no_spurious_victim: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_i && !hit_i) |=> !victim_vld_o);

    // R9: mode holds while accesses are present
    a_r9_mode_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i || alloc_i) |=> $stable(mode_q));

    // R4: split mode confines instruction victims to ways 0..1
    a_r4_half_inst_group: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !hit_i && mode_q == 2'b01 && !acc_is_data_i) |=> (victim_o < 2'd2));

    // R4: split mode confines data victims to ways 2..3
    a_r4_half_data_group: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !hit_i && mode_q == 2'b01 && acc_is_data_i) |=> (victim_o >= 2'd2));

    // R5: three-plus-one mode gives data way 3 and instructions ways 0..2
    a_r5_data_way3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !hit_i && mode_q == 2'b10 && acc_is_data_i) |=> (victim_o == 2'd3));
    a_r5_inst_low3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !hit_i && mode_q == 2'b10 && !acc_is_data_i) |=> (victim_o != 2'd3));
endmodule

bind wplru_victim_sel wplru_victim_sel_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_q        (mode_q),
    .acc_is_data_i (acc_is_data_i),
    .hit_i         (hit_i),
    .alloc_i       (alloc_i),
    .victim_o      (victim_o),
    .victim_vld_o  (victim_vld_o)
);

// File: tb/wplru_victim_sel_tb_top.sv
`timescale 1ns/1ps
module wplru_victim_sel_tb_top;
    localparam int NSETS = 8;
    localparam int SET_W = $clog2(NSETS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode_i = '0;
    logic [SET_W-1:0] acc_set_i = '0;
    logic             acc_is_data_i = 1'b0;
    logic             hit_i = 1'b0;
    logic [1:0]       hit_way_i = '0;
    logic             alloc_i = 1'b0;
    logic [1:0]       victim_o;
    logic             victim_vld_o;

    int checks = 0;
    int failures = 0;
    int ts [NSETS][4];
    int now_ts = 10;
    int m_mode = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    wplru_victim_sel #(.NSETS(NSETS)) dut_i (
        .clk (clk), .rst_n (rst_n), .mode_i (mode_i), .acc_set_i (acc_set_i),
        .acc_is_data_i (acc_is_data_i), .hit_i (hit_i), .hit_way_i (hit_way_i),
        .alloc_i (alloc_i), .victim_o (victim_o), .victim_vld_o (victim_vld_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic bit allowed(input int md, input bit dat, input int w);
        if (md == 1) return dat ? (w >= 2) : (w < 2);
        if (md == 2) return dat ? (w == 3) : (w < 3);
        return 1'b1;
    endfunction

    function automatic int model_victim(input int s, input bit dat);
        int best = -1;
        for (int w = 0; w < 4; w++)
            if (allowed(m_mode, dat, w) && (best < 0 || ts[s][w] < ts[s][best])) best = w;
        return best;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < 4; w++) ts[s][w] = w;
        m_mode = 0;
    endtask

    // One access cycle: drive at negedge, check after the next rising edge.
    task automatic acc(input bit h, input int hw, input bit al, input int s,
                       input bit dat, input int md, input string req);
        int exp_v = 0;
        bit exp_vld = 0;
        hit_i = h; hit_way_i = 2'(hw); alloc_i = al; acc_set_i = SET_W'(s);
        acc_is_data_i = dat; mode_i = 2'(md);
        if (h) begin
            now_ts++; ts[s][hw] = now_ts;
        end else if (al) begin
            exp_v = model_victim(s, dat); exp_vld = 1;
            now_ts++; ts[s][exp_v] = now_ts;
        end else begin
            m_mode = md;
        end
        @(posedge clk);
        @(negedge clk);
        hit_i = 0; alloc_i = 0;
        chk(victim_vld_o == exp_vld, req, int'(victim_vld_o), int'(exp_vld));
        if (exp_vld) chk(victim_o == 2'(exp_v), req, int'(victim_o), exp_v);
    endtask

    task automatic idle_mode(input int md);
        acc(0, 0, 0, 0, 0, md, "R9");
    endtask

    task automatic t_reset();
        chk(victim_vld_o == 1'b0, "R1", int'(victim_vld_o), 0);
        acc(0, 0, 1, 0, 0, 0, "R1");
        acc(0, 0, 1, 1, 1, 0, "R1");
    endtask

    task automatic t_shared_rotation();
        for (int k = 0; k < 6; k++) acc(0, 0, 1, 2, k % 2, 0, "R3_R7");
    endtask

    task automatic t_hit_touch();
        acc(1, 1, 0, 3, 0, 0, "R6");
        acc(1, 0, 0, 3, 1, 0, "R6");
        acc(0, 0, 1, 3, 0, 0, "R6");
        acc(0, 0, 1, 3, 0, 0, "R6");
    endtask

    task automatic t_half_mode();
        idle_mode(1);
        acc(0, 0, 1, 4, 0, 0, "R4");
        acc(0, 0, 1, 4, 1, 0, "R4");
        acc(0, 0, 1, 4, 0, 0, "R4");
        acc(1, 2, 0, 4, 0, 0, "R6");
        acc(0, 0, 1, 4, 1, 0, "R4");
        acc(0, 0, 1, 4, 1, 0, "R4");
    endtask

    task automatic t_three_one_mode();
        idle_mode(2);
        for (int k = 0; k < 4; k++) acc(0, 0, 1, 5, 1, 0, "R5");
        for (int k = 0; k < 4; k++) acc(0, 0, 1, 5, 0, 0, "R5");
    endtask

    task automatic t_mode_busy();
        idle_mode(0);
        for (int k = 0; k < 4; k++) acc(0, 0, 1, 6, 1, 2, "R9");
        idle_mode(3);
        for (int k = 0; k < 3; k++) acc(0, 0, 1, 6, 0, 1, "R3");
    endtask

    task automatic t_hit_and_alloc();
        acc(1, 3, 1, 7, 0, 0, "R8");
        acc(1, 0, 1, 7, 1, 0, "R8");
        acc(0, 0, 1, 7, 0, 0, "R8");
    endtask

    task automatic t_set_isolation();
        acc(0, 0, 1, 1, 0, 0, "R10");
        acc(0, 0, 1, 0, 0, 0, "R10");
        acc(0, 0, 1, 7, 1, 0, "R10");
        acc(0, 0, 1, 1, 1, 0, "R10");
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_shared_rotation();
        t_hit_touch();
        t_half_mode();
        t_three_one_mode();
        t_mode_busy();
        t_hit_and_alloc();
        t_set_isolation();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule